// File: doc/BRIEF.md
# Suspend-Well Power Rail Sequencer

This block powers a platform's suspend well up and down. After reset it waits for the real-time-clock well to settle. It then enters the deep-sleep-well state and runs the suspend-well power-up sequence on its own. The sequence drives the rail enables, the deep-sleep-well power-ok, the resume-reset release, the suspend-acknowledge release and finally the sleep-control handoff enable, with a timed gap between steps.

Two active-low request inputs, a suspend warning and an S3 sleep indication, decide whether the primary well must stay powered. When neither is low and the well is up, the block tears the well down in the reverse order and returns to the deep-sleep-well state. When one of them goes low again, it powers the well back up.

A platform power-good input feeds two power-ok outputs. Both are held low unless the well is fully up and no sequence is running. They are forced low at the first step of a power-down. Every delay is a cycle count derived from the `CLK_HZ` parameter, and one shared down-counter times all the steps.

Top module: `pwr_rail_seq`

## Requirements
- R1: While reset is high and on the first cycle after it, `pwr_state` is 0 (default), `busy` is 1, and every rail enable, power-ok, `susp_ack_n`, `resume_rst_n` and `sleep_handoff_en` is 0.
- R2: A wait of t seconds lasts max(1, ceil(t × CLK_HZ)) clock cycles. The first wait is 9 ms: `prim_rail_en` rises, and `pwr_state` becomes 1 (deep-sleep well), on the rising edge numbered ceil(9 ms × CLK_HZ) after reset is released.
- R3: Power-up timing. `prim_rail_en` rises first. After 200 µs, `v5_rail_en` and `susp_ack_n` rise on the same edge. After a further 10 ms, `dsw_pwr_ok` and `resume_rst_n` rise on the same edge. After a further 95 ms, `sleep_handoff_en` rises and `pwr_state` becomes 2 (suspend power), both on the same edge.
- R4: Power-down timing. `ctrl_pwr_ok`, `sys_pwr_ok`, `sleep_handoff_en`, `resume_rst_n` and `v5_rail_en` all drop on one edge. 400 ns later, `prim_rail_en` and `dsw_pwr_ok` drop. After another 400 ns, `pwr_state` returns to 1 and `busy` falls. `susp_ack_n` stays high.
- R5: The primary well is needed when `susp_warn_n` is 0 or `s3_sleep_n` is 0. When idle in state 1 and the well is needed, power-up starts. When idle in state 2 and the well is not needed, power-down starts.
- R6: `susp_warn_n`, `s3_sleep_n` and `plat_pwr_good` pass through a two-flop synchronizer. A change applied between edges takes effect at the block's outputs on the third rising edge after it is applied.
- R7: `busy` is 1 during the 9 ms wait and during every power-up or power-down, and 0 otherwise. A request change while `busy` is 1 does not alter the running sequence. One edge after the sequence completes, the request is evaluated again.
- R8: While idle in state 2, `ctrl_pwr_ok` follows the synchronized `plat_pwr_good` on the next edge. `sys_pwr_ok` rises one edge after `ctrl_pwr_ok` and falls on the same edge as it. In every other case both are 0. On the edge where a power-down starts, the forced low wins over a power-good that rises at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at CLK_HZ |
| rst | input | 1 | Synchronous active-high reset |
| susp_warn_n | input | 1 | Active-low suspend warning (well needed when 0) |
| s3_sleep_n | input | 1 | Active-low S3 sleep indication (well needed when 0) |
| plat_pwr_good | input | 1 | Platform power-good level |
| prim_rail_en | output | 1 | Primary suspend rail enable |
| v5_rail_en | output | 1 | 5 V rail enable |
| susp_ack_n | output | 1 | Suspend acknowledge, released high during power-up |
| dsw_pwr_ok | output | 1 | Deep-sleep-well power-ok |
| resume_rst_n | output | 1 | Active-low resume reset |
| sleep_handoff_en | output | 1 | Hands sleep-control signals to the host |
| ctrl_pwr_ok | output | 1 | Controller power-ok |
| sys_pwr_ok | output | 1 | System power-ok |
| busy | output | 1 | High while a timed wait or sequence runs |
| pwr_state | output | 3 | 0 default, 1 deep-sleep well, 2 suspend power |

## Verification
Two functions can collide on the same edge: the start of a power-down and a rising platform power-good that would otherwise raise `ctrl_pwr_ok`. The bench provokes this by raising `plat_pwr_good` and withdrawing the well request in the same half-cycle, while the well is up with power-good low. Both changes therefore leave the synchronizer together. The result is judged correct if `ctrl_pwr_ok` never rises and `v5_rail_en` falls exactly three edges later. A second near-collision, a withdrawn request waiting behind a running power-up, is checked by requiring power-down to begin one edge after `sleep_handoff_en` rises.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

    typedef enum logic [2:0] {
        PST_DEFAULT = 3'd0,
        PST_DSW     = 3'd1,
        PST_SUSP    = 3'd2
    } pst_e;

    typedef enum logic [2:0] {
        PH_RTC,
        PH_IDLE,
        PH_UP_PRIM,
        PH_UP_V5,
        PH_UP_DSW,
        PH_DN_V5,
        PH_DN_PRIM
    } phase_e;

    typedef struct packed {
        logic sys_pwr_ok;
        logic ctrl_pwr_ok;
        logic handoff_en;
        logic rsm_rst_n;
        logic dsw_pwr_ok;
        logic susp_ack_n;
        logic v5_en;
        logic prim_en;
    } rail_t;

    // Step durations in nanoseconds
    localparam longint unsigned T_RTC_NS   = 64'd9_000_000;
    localparam longint unsigned T_PRIM_NS  = 64'd200_000;
    localparam longint unsigned T_V5_NS    = 64'd10_000_000;
    localparam longint unsigned T_DSW_NS   = 64'd95_000_000;
    localparam longint unsigned T_DROP_NS  = 64'd400;

    // Cycles for a duration: ceiling of time times frequency, at least one
    function automatic longint unsigned delay_cycles(input longint unsigned t_ns,
                                                     input longint unsigned clk_hz);
        longint unsigned c;
        c = (t_ns * clk_hz + 64'd999_999_999) / 64'd1_000_000_000;
        return (c == 64'd0) ? 64'd1 : c;
    endfunction

    function automatic longint unsigned max2(input longint unsigned a,
                                             input longint unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/pwrseq_sync.sv
module pwrseq_sync #(
    parameter int          W       = 3,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= RST_VAL;
        end else begin
            stage_q[0] <= d;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/pwrseq_timer.sv
module pwrseq_timer #(
    parameter int              CNT_W   = 8,
    parameter logic [CNT_W-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)               cnt_q <= RST_VAL;
        else if (load)         cnt_q <= load_val;
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);

    // R2: an expired counter stays at zero until it is reloaded
    assert_timer_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (zero && !load) |=> zero);
endmodule

// File: rtl/pwrseq_ctrl.sv
module pwrseq_ctrl
    import pwrseq_pkg::*;
#(
    parameter int               CNT_W    = 8,
    parameter logic [CNT_W-1:0] LD_PRIM  = '0,
    parameter logic [CNT_W-1:0] LD_V5    = '0,
    parameter logic [CNT_W-1:0] LD_DSW   = '0,
    parameter logic [CNT_W-1:0] LD_DROP  = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             need_prim,
    input  logic             good_s,
    input  logic             tmr_zero,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output rail_t            rails,
    output logic             busy,
    output logic [2:0]       state
);
    phase_e ph_q;
    pst_e   pst_q;
    rail_t  r_q;
    logic   start_up, start_dn, up_ok;

    assign start_up = (ph_q == PH_IDLE) && (pst_q == PST_DSW)  &&  need_prim;
    assign start_dn = (ph_q == PH_IDLE) && (pst_q == PST_SUSP) && !need_prim;
    assign up_ok    = (ph_q == PH_IDLE) && (pst_q == PST_SUSP) && good_s;

    // Counter reload on every step transition
    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (ph_q)
            PH_RTC:     if (tmr_zero) begin tmr_load = 1'b1; tmr_val = LD_PRIM; end
            PH_UP_PRIM: if (tmr_zero) begin tmr_load = 1'b1; tmr_val = LD_V5;   end
            PH_UP_V5:   if (tmr_zero) begin tmr_load = 1'b1; tmr_val = LD_DSW;  end
            PH_IDLE: begin
                if (start_up)      begin tmr_load = 1'b1; tmr_val = LD_PRIM; end
                else if (start_dn) begin tmr_load = 1'b1; tmr_val = LD_DROP; end
            end
            PH_DN_V5:   if (tmr_zero) begin tmr_load = 1'b1; tmr_val = LD_DROP; end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q  <= PH_RTC;
            pst_q <= PST_DEFAULT;
            r_q   <= '0;
        end else begin
            r_q.ctrl_pwr_ok <= up_ok;
            r_q.sys_pwr_ok  <= up_ok && r_q.ctrl_pwr_ok;
            unique case (ph_q)
                PH_RTC: if (tmr_zero) begin
                    pst_q      <= PST_DSW;
                    r_q.prim_en <= 1'b1;
                    ph_q       <= PH_UP_PRIM;
                end
                PH_UP_PRIM: if (tmr_zero) begin
                    r_q.v5_en      <= 1'b1;
                    r_q.susp_ack_n <= 1'b1;
                    ph_q           <= PH_UP_V5;
                end
                PH_UP_V5: if (tmr_zero) begin
                    r_q.dsw_pwr_ok <= 1'b1;
                    r_q.rsm_rst_n  <= 1'b1;
                    ph_q           <= PH_UP_DSW;
                end
                PH_UP_DSW: if (tmr_zero) begin
                    r_q.handoff_en <= 1'b1;
                    pst_q          <= PST_SUSP;
                    ph_q           <= PH_IDLE;
                end
                PH_IDLE: begin
                    if (start_up) begin
                        r_q.prim_en <= 1'b1;
                        ph_q        <= PH_UP_PRIM;
                    end else if (start_dn) begin
                        r_q.sys_pwr_ok  <= 1'b0;
                        r_q.ctrl_pwr_ok <= 1'b0;
                        r_q.handoff_en  <= 1'b0;
                        r_q.rsm_rst_n   <= 1'b0;
                        r_q.v5_en       <= 1'b0;
                        ph_q            <= PH_DN_V5;
                    end
                end
                PH_DN_V5: if (tmr_zero) begin
                    r_q.prim_en    <= 1'b0;
                    r_q.dsw_pwr_ok <= 1'b0;
                    ph_q           <= PH_DN_PRIM;
                end
                PH_DN_PRIM: if (tmr_zero) begin
                    pst_q <= PST_DSW;
                    ph_q  <= PH_IDLE;
                end
                default: ph_q <= PH_IDLE;
            endcase
        end
    end

    assign rails = r_q;
    assign busy  = (ph_q != PH_IDLE);
    assign state = pst_q;

    // R1: only the three state codes ever appear
    assert_state_legal_R1: assert property (@(posedge clk) disable iff (rst)
        state <= 3'd2);
    // R3: the 5 V rail is never on without the primary rail
    assert_v5_needs_prim_R3: assert property (@(posedge clk) disable iff (rst)
        rails.v5_en |-> rails.prim_en);
    // R3: handoff only with the deep-sleep well good and resume reset released
    assert_handoff_ready_R3: assert property (@(posedge clk) disable iff (rst)
        rails.handoff_en |-> (rails.dsw_pwr_ok && rails.rsm_rst_n));
    // R4: primary rail drops only after the 5 V rail is already off
    assert_prim_after_v5_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(rails.prim_en) |-> !rails.v5_en);
    // R4: suspend acknowledge is never pulled back low
    assert_ack_sticky_R4: assert property (@(posedge clk) disable iff (rst)
        !$fell(rails.susp_ack_n));
    // R7: idle never happens in the default state
    assert_idle_not_default_R7: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (state != 3'd0));
    // R8: power-ok outputs only while the well is handed off
    assert_pwrok_gate_R8: assert property (@(posedge clk) disable iff (rst)
        rails.ctrl_pwr_ok |-> (rails.handoff_en && !busy));
    assert_sys_after_ctrl_R8: assert property (@(posedge clk) disable iff (rst)
        rails.sys_pwr_ok |-> rails.ctrl_pwr_ok);
endmodule

// File: rtl/pwr_rail_seq.sv
module pwr_rail_seq
    import pwrseq_pkg::*;
#(
    parameter longint unsigned CLK_HZ = 64'd32_000_000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       susp_warn_n,
    input  logic       s3_sleep_n,
    input  logic       plat_pwr_good,
    output logic       prim_rail_en,
    output logic       v5_rail_en,
    output logic       susp_ack_n,
    output logic       dsw_pwr_ok,
    output logic       resume_rst_n,
    output logic       sleep_handoff_en,
    output logic       ctrl_pwr_ok,
    output logic       sys_pwr_ok,
    output logic       busy,
    output logic [2:0] pwr_state
);
    localparam longint unsigned D_RTC  = delay_cycles(T_RTC_NS,  CLK_HZ);
    localparam longint unsigned D_PRIM = delay_cycles(T_PRIM_NS, CLK_HZ);
    localparam longint unsigned D_V5   = delay_cycles(T_V5_NS,   CLK_HZ);
    localparam longint unsigned D_DSW  = delay_cycles(T_DSW_NS,  CLK_HZ);
    localparam longint unsigned D_DROP = delay_cycles(T_DROP_NS, CLK_HZ);
    localparam longint unsigned D_MAX  = max2(max2(D_RTC, D_PRIM),
                                              max2(max2(D_V5, D_DSW), D_DROP));
    localparam int CNT_W = $clog2(D_MAX + 1);

    logic [2:0]       req_raw, req_s;
    logic             need_prim, tmr_zero, tmr_load;
    logic [CNT_W-1:0] tmr_val;
    rail_t            rails;

    assign req_raw = {plat_pwr_good, s3_sleep_n, susp_warn_n};

    pwrseq_sync #(.W(3), .STAGES(2), .RST_VAL(3'b011)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (req_raw),
        .q   (req_s)
    );

    assign need_prim = !req_s[0] || !req_s[1];

    pwrseq_timer #(.CNT_W(CNT_W), .RST_VAL(CNT_W'(D_RTC - 1))) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    pwrseq_ctrl #(
        .CNT_W   (CNT_W),
        .LD_PRIM (CNT_W'(D_PRIM - 1)),
        .LD_V5   (CNT_W'(D_V5 - 1)),
        .LD_DSW  (CNT_W'(D_DSW - 1)),
        .LD_DROP (CNT_W'(D_DROP - 1))
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .need_prim (need_prim),
        .good_s    (req_s[2]),
        .tmr_zero  (tmr_zero),
        .tmr_load  (tmr_load),
        .tmr_val   (tmr_val),
        .rails     (rails),
        .busy      (busy),
        .state     (pwr_state)
    );

    assign prim_rail_en     = rails.prim_en;
    assign v5_rail_en       = rails.v5_en;
    assign susp_ack_n       = rails.susp_ack_n;
    assign dsw_pwr_ok       = rails.dsw_pwr_ok;
    assign resume_rst_n     = rails.rsm_rst_n;
    assign sleep_handoff_en = rails.handoff_en;
    assign ctrl_pwr_ok      = rails.ctrl_pwr_ok;
    assign sys_pwr_ok       = rails.sys_pwr_ok;
endmodule

// File: tb/pwr_rail_seq_tb.sv
module pwr_rail_seq_tb_top;
    localparam longint unsigned HZ = 64'd20_000;

    function automatic longint cyc_for(input longint t_ns);
        longint c;
        c = (t_ns * longint'(HZ) + 64'd999_999_999) / 64'd1_000_000_000;
        return (c < 1) ? 1 : c;
    endfunction

    localparam longint C_RTC  = cyc_for(9_000_000);
    localparam longint C_PRIM = cyc_for(200_000);
    localparam longint C_V5   = cyc_for(10_000_000);
    localparam longint C_DSW  = cyc_for(95_000_000);
    localparam longint C_DROP = cyc_for(400);

    logic clk = 1'b0, rst = 1'b1;
    logic swn = 1'b1, s3n = 1'b0, pgood = 1'b0;
    logic prim, v5, sack, dsw, rsm, hand, cpok, spok, busy;
    logic [2:0] st;

    pwr_rail_seq #(.CLK_HZ(HZ)) dut_i (
        .clk(clk), .rst(rst), .susp_warn_n(swn), .s3_sleep_n(s3n),
        .plat_pwr_good(pgood), .prim_rail_en(prim), .v5_rail_en(v5),
        .susp_ack_n(sack), .dsw_pwr_ok(dsw), .resume_rst_n(rsm),
        .sleep_handoff_en(hand), .ctrl_pwr_ok(cpok), .sys_pwr_ok(spok),
        .busy(busy), .pwr_state(st)
    );

    always #5 clk = ~clk;

    longint cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // Event recorder: bit 0 prim,1 v5,2 sack,3 dsw,4 rsm,5 hand,6 cpok,7 spok
    logic [7:0] mon, prev_mon = '0;
    logic [2:0] prev_st = '0;
    longint t_rise [8];
    longint t_fall [8];
    longint t_st = -1;
    assign mon = {spok, cpok, hand, rsm, dsw, sack, v5, prim};
    initial for (int i = 0; i < 8; i++) begin t_rise[i] = -1; t_fall[i] = -1; end
    always @(negedge clk) begin
        for (int i = 0; i < 8; i++) begin
            if (mon[i] && !prev_mon[i]) t_rise[i] = cyc;
            if (!mon[i] && prev_mon[i]) t_fall[i] = cyc;
        end
        if (st != prev_st) t_st = cyc;
        prev_mon = mon;
        prev_st  = st;
    end

    int checks = 0, fails = 0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk); #1;
    endtask

    task automatic settle();
        int quiet = 0;
        while (quiet < 4) begin
            tick();
            quiet = busy ? 0 : quiet + 1;
        end
    endtask

    function automatic bit exp_need(input logic w, input logic s);
        return !w || !s;
    endfunction

    task automatic chk_rest(input string tag, input bit up);
        chk(st == (up ? 3'd2 : 3'd1), {tag, " state"}, st, up ? 2 : 1);
        chk({prim, v5, dsw, rsm, hand} == (up ? 5'b11111 : 5'b00000),
            {tag, " rails"}, {prim, v5, dsw, rsm, hand}, up ? 31 : 0);
        chk(sack == 1'b1, {tag, " ack"}, sack, 1);
    endtask

    initial begin
        longint rel, c, r6;
        void'($urandom(32'h00C0FFEE));
        repeat (3) tick();
        // R1: reset state
        chk(st == 3'd0 && busy == 1'b1, "R1 state/busy", {st, busy}, 1);
        chk(mon == 8'h00, "R1 outputs", mon, 0);
        rst = 1'b0;
        rel = cyc;
        tick();
        chk(st == 3'd0 && mon == 8'h00 && busy, "R1 first cycle", {st, mon}, 0);
        settle();
        // R2: RTC wait length
        chk(t_rise[0] - rel == C_RTC, "R2 rtc wait", t_rise[0] - rel, C_RTC);
        // R3: power-up order and gaps
        chk(t_rise[1] - t_rise[0] == C_PRIM && t_rise[2] == t_rise[1],
            "R3 v5/ack step", t_rise[1] - t_rise[0], C_PRIM);
        chk(t_rise[3] - t_rise[1] == C_V5 && t_rise[4] == t_rise[3],
            "R3 dsw/rsm step", t_rise[3] - t_rise[1], C_V5);
        chk(t_rise[5] - t_rise[3] == C_DSW && t_st == t_rise[5],
            "R3 handoff step", t_rise[5] - t_rise[3], C_DSW);
        chk_rest("R3 end", 1'b1);
        chk(cpok == 1'b0 && spok == 1'b0, "R8 no good yet", {cpok, spok}, 0);

        // R8 / R6: power-good path
        c = cyc; pgood = 1'b1;
        repeat (6) tick();
        chk(t_rise[6] == c + 3, "R8 R6 ctrl rise", t_rise[6] - c, 3);
        chk(t_rise[7] == c + 4, "R8 sys rise", t_rise[7] - c, 4);
        c = cyc; pgood = 1'b0;
        repeat (6) tick();
        chk(t_fall[6] == c + 3 && t_fall[7] == c + 3, "R8 both fall", t_fall[7] - c, 3);
        pgood = 1'b1;
        repeat (6) tick();

        // R4 / R5 / R6: power-down when neither input requests the well
        c = cyc; s3n = 1'b1;
        settle();
        chk(t_fall[1] == c + 3 && t_fall[4] == c + 3 && t_fall[5] == c + 3,
            "R4 R6 first drop", t_fall[1] - c, 3);
        chk(t_fall[6] == c + 3 && t_fall[7] == c + 3, "R4 pwrok drop", t_fall[6] - c, 3);
        chk(t_fall[0] == c + 3 + C_DROP && t_fall[3] == t_fall[0],
            "R4 prim/dsw drop", t_fall[0] - c, 3 + C_DROP);
        chk(t_st == c + 3 + 2 * C_DROP, "R4 state back", t_st - c, 3 + 2 * C_DROP);
        chk_rest("R4 end", 1'b0);

        // R5: suspend warning alone requests the well
        c = cyc; swn = 1'b0;
        settle();
        chk(t_rise[0] == c + 3, "R5 warn starts up", t_rise[0] - c, 3);
        chk_rest("R5 up", 1'b1);

        // Same-edge conflict: power-good rise and power-down start together
        pgood = 1'b0;
        repeat (6) tick();
        r6 = t_rise[6];
        c = cyc; pgood = 1'b1; swn = 1'b1;
        settle();
        chk(t_rise[6] == r6 && cpok == 1'b0, "R8 forced low wins", t_rise[6], r6);
        chk(t_fall[1] == c + 3, "R4 conflict drop", t_fall[1] - c, 3);
        pgood = 1'b0;

        // R7: withdrawn request during power-up is deferred
        c = cyc; s3n = 1'b0;
        repeat (20) tick();
        chk(busy == 1'b1, "R7 busy mid", busy, 1);
        s3n = 1'b1;
        settle();
        chk(t_rise[5] == c + 3 + C_PRIM + C_V5 + C_DSW, "R7 up completes",
            t_rise[5] - c, 3 + C_PRIM + C_V5 + C_DSW);
        chk(t_fall[1] == t_rise[5] + 1, "R7 re-evaluated", t_fall[1] - t_rise[5], 1);
        chk_rest("R7 end", 1'b0);

        // Random request patterns (R5, R7)
        for (int k = 0; k < 8; k++) begin
            logic [1:0] p;
            p = 2'($urandom % 4);
            swn = p[0]; s3n = p[1];
            repeat ($urandom % 300) tick();
            p = 2'($urandom % 4);
            swn = p[0]; s3n = p[1];
            repeat (4) tick();
            settle();
            chk_rest($sformatf("R5 R7 random %0d", k), exp_need(swn, s3n));
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=0", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule